// File: doc/BRIEF.md
# Cluster Shutdown Agent

Each cluster that can host a virtual machine carries one shutdown agent. When a central controller addresses a shutdown command to it, the agent holds a soft-reset line to every core of the cluster for a fixed number of cycles. It then waits until each participating core has reported that its cleanup is complete. Only then does it pulse the deactivate input of every address translator in the cluster, which covers the core translators, the DMA translator and the peripheral translator. It finishes by raising a report toward the controller and holding it until the controller acknowledges.

The agent keeps two configuration bytes: a participation mask that selects which cores it waits on, and its own identifier. A command is taken only when its destination matches that identifier and the agent is idle. The configuration is locked while a shutdown is in progress, so the set of cores being waited on cannot be changed partway through a teardown.

Top module: `cluster_teardown_agent`

## Requirements
- R1: After reset, all soft-reset outputs, all deactivate outputs and the report valid output are low. The participation mask resets to all ones and the identifier resets to zero.
- R2: An accepted command raises every bit of `core_srst`, whatever the mask, from the clock edge that samples the command. The bits stay high for exactly RST_CYCLES cycles (default 4) and then fall together.
- R3: A command whose `cmd_dest` differs from the stored identifier is ignored, and no soft reset follows it.
- R4: Completion inputs are sticky. A single-cycle pulse on `core_done[i]` counts as completion of core i for the rest of that shutdown.
- R5: No deactivate pulse is issued while any participating core has not yet reported completion.
- R6: Cores whose mask bit is 0 are not waited on. With an all-zero mask, deactivation follows one cycle after the soft-reset phase ends.
- R7: When the wait ends, all NXLAT bits of `xlat_deact` are high together for exactly one cycle. They are never high at the same time as soft reset.
- R8: `rsp_valid` rises on the cycle after the deactivate pulse, carries the identifier on `rsp_id`, and stays high until a cycle with `rsp_ack` high. It is low on the cycle after the acknowledge.
- R9: A command that arrives while a shutdown is in progress is ignored. The soft-reset phase is not extended or restarted, and a command during the wait phase raises no soft reset.
- R10: A configuration write with `cfg_sel`=0 loads the mask from the low NCORE bits of `cfg_wdata`. A write with `cfg_sel`=1 loads the identifier from the low ID_W bits. Writes are ignored unless the agent is idle.
- R11: Completion inputs are sampled only during the wait phase. A completion that is asserted only during the soft-reset phase does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mask byte, 1 selects the identifier byte |
| cfg_wdata | input | 8 | Configuration write data |
| cmd_valid | input | 1 | Shutdown command strobe |
| cmd_dest | input | ID_W | Identifier of the addressed agent |
| core_srst | output | NCORE | Soft reset to each core |
| core_done | input | NCORE | Cleanup completion from each core |
| xlat_deact | output | NXLAT | Deactivate pulse to each address translator |
| rsp_valid | output | 1 | Shutdown report pending |
| rsp_id | output | ID_W | Identifier of the reporting agent |
| rsp_ack | input | 1 | Controller acknowledge of the report |

## Verification
A wrong phase register can cause a deactivate pulse to fire before every participating core has reported. It can also make the report appear without a deactivate pulse, or keep soft reset high past its fixed length. Each of these shows at the ports within one or two cycles of the transition. Errors in the completion register show up differently. A non-sticky register stalls the agent after single-cycle pulses. A register that sampled too early lets the agent finish when completions were raised only during reset. A register that was not cleared carries a finished state into the next shutdown. A stale mask or identifier shows either as a wait on the wrong cores or as a report carrying the wrong identifier.

// File: rtl/cluster_teardown_agent.sv
module cluster_teardown_agent #(
  parameter int NCORE      = 4,
  parameter int NXLAT      = 6,
  parameter int RST_CYCLES = 4,
  parameter int ID_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             cmd_valid,
  input  logic [ID_W-1:0]  cmd_dest,
  output logic [NCORE-1:0] core_srst,
  input  logic [NCORE-1:0] core_done,
  output logic [NXLAT-1:0] xlat_deact,
  output logic             rsp_valid,
  output logic [ID_W-1:0]  rsp_id,
  input  logic             rsp_ack
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RESET, S_WAIT, S_DEACT, S_REPORT} phase_t;

  phase_t           phase;
  logic [CW-1:0]    rcnt;
  logic [NCORE-1:0] done_q;
  logic [NCORE-1:0] mask_q;
  logic [ID_W-1:0]  id_q;

  logic [NCORE-1:0] done_seen;
  logic             all_done;
  logic             take_cmd;

  assign done_seen = done_q | core_done;
  assign all_done  = ((done_seen & mask_q) == mask_q);
  assign take_cmd  = (phase == S_IDLE) && cmd_valid && (cmd_dest == id_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      id_q   <= '0;
    end else if (cfg_we && phase == S_IDLE) begin
      if (cfg_sel) id_q   <= cfg_wdata[ID_W-1:0];
      else         mask_q <= cfg_wdata[NCORE-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= S_IDLE;
      rcnt   <= '0;
      done_q <= '0;
    end else begin
      case (phase)
        S_IDLE: if (take_cmd) begin
          phase  <= S_RESET;
          rcnt   <= '0;
          done_q <= '0;
        end
        S_RESET: begin
          if (rcnt == CW'(RST_CYCLES - 1)) phase <= S_WAIT;
          else rcnt <= rcnt + 1'b1;
        end
        S_WAIT: begin
          done_q <= done_seen;
          if (all_done) phase <= S_DEACT;
        end
        S_DEACT:  phase <= S_REPORT;
        S_REPORT: if (rsp_ack) phase <= S_IDLE;
        default:  phase <= S_IDLE;
      endcase
    end
  end

  assign core_srst  = {NCORE{phase == S_RESET}};
  assign xlat_deact = {NXLAT{phase == S_DEACT}};
  assign rsp_valid  = (phase == S_REPORT);
  assign rsp_id     = id_q;

endmodule

// File: rtl/cluster_teardown_agent_chk.sv
module cluster_teardown_agent_chk #(
  parameter int NCORE      = 4,
  parameter int NXLAT      = 6,
  parameter int RST_CYCLES = 4,
  parameter int ID_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] core_srst,
  input logic [NXLAT-1:0] xlat_deact,
  input logic             rsp_valid,
  input logic [ID_W-1:0]  rsp_id,
  input logic             rsp_ack
);

  int  srst_run;
  logic srst_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_run  <= 0;
      srst_prev <= 1'b0;
    end else begin
      srst_run  <= (|core_srst) ? srst_run + 1 : 0;
      srst_prev <= |core_srst;
    end
  end

  // R2
  srst_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_srst) |-> (&core_srst));

  // R2
  srst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_srst) |-> (srst_run < RST_CYCLES));

  // R2
  srst_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_prev && !(|core_srst)) |-> (srst_run == RST_CYCLES));

  // R7
  deact_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|xlat_deact) |=> !(|xlat_deact));

  // R7
  deact_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|xlat_deact) && (|core_srst)));

  // R8
  deact_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|xlat_deact) |=> rsp_valid);

  // R8
  report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_id)));

  // R8
  report_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ack) |=> !rsp_valid);

  // R9
  report_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(|core_srst) && !(|xlat_deact));

endmodule

bind cluster_teardown_agent cluster_teardown_agent_chk #(
  .NCORE(NCORE), .NXLAT(NXLAT), .RST_CYCLES(RST_CYCLES), .ID_W(ID_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .core_srst(core_srst), .xlat_deact(xlat_deact),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ack(rsp_ack)
);

// File: tb/cluster_teardown_agent_test.sv
`timescale 1ns/1ps
module cluster_teardown_agent_test;
  localparam int NCORE = 4, NXLAT = 6, RSTC = 4, ID_W = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic cmd_valid = 0;
  logic [ID_W-1:0] cmd_dest = 0;
  logic [NCORE-1:0] core_srst, core_done = 0;
  logic [NXLAT-1:0] xlat_deact;
  logic rsp_valid, rsp_ack = 0;
  logic [ID_W-1:0] rsp_id;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  cluster_teardown_agent #(.NCORE(NCORE), .NXLAT(NXLAT), .RST_CYCLES(RSTC), .ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_valid(cmd_valid), .cmd_dest(cmd_dest), .core_srst(core_srst), .core_done(core_done),
    .xlat_deact(xlat_deact), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ack(rsp_ack));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(logic sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_cmd(logic [ID_W-1:0] d);
    cmd_valid = 1; cmd_dest = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic count_srst(output int n);
    n = 0;
    while (core_srst == '1 && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run(logic [ID_W-1:0] exp_id, string tag);
    core_done = '1;
    @(negedge clk);
    check({tag, " R7 deact all"}, 32'(xlat_deact), 32'h3f);
    core_done = '0;
    @(negedge clk);
    check({tag, " R7 deact one cycle"}, 32'(xlat_deact), 0);
    check({tag, " R8 rsp_valid"}, 32'(rsp_valid), 1);
    check({tag, " R8 rsp_id"}, 32'(rsp_id), 32'(exp_id));
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    check({tag, " R8 rsp dropped"}, 32'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 srst", 32'(core_srst), 0);
    check("R1 deact", 32'(xlat_deact), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 rsp_id", 32'(rsp_id), 0);
  endtask

  task automatic t_basic();
    int n;
    send_cmd(0);
    count_srst(n);
    check("R2 srst length", 32'(n), RSTC);
    for (int i = 0; i < 3; i++) begin
      core_done = NCORE'(1 << i);
      @(negedge clk);
      core_done = 0;
      @(negedge clk);
      check("R5 no early deact", 32'(xlat_deact), 0);
    end
    repeat (3) @(negedge clk);
    check("R4 still waiting", 32'(xlat_deact | NXLAT'(rsp_valid)), 0);
    core_done = 4'b1000;
    @(negedge clk);
    core_done = 0;
    check("R4 sticky pulses deact", 32'(xlat_deact), 32'h3f);
    @(negedge clk);
    check("R7 deact single", 32'(xlat_deact), 0);
    check("R8 report up", 32'(rsp_valid), 1);
    repeat (3) @(negedge clk);
    check("R8 report held", 32'(rsp_valid), 1);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    check("R8 report cleared", 32'(rsp_valid), 0);
  endtask

  task automatic t_ident();
    int n;
    cfg_write(1, 8'h05);
    send_cmd(0);
    repeat (2) @(negedge clk);
    check("R3 wrong dest ignored", 32'(core_srst), 0);
    send_cmd(5);
    count_srst(n);
    check("R10 new id accepted", 32'(n), RSTC);
    finish_run(5, "R10 id");
  endtask

  task automatic t_mask();
    int n;
    cfg_write(0, 8'h05);
    send_cmd(5);
    check("R2 srst ignores mask", 32'(core_srst), 32'hf);
    count_srst(n);
    core_done = 4'b0001;
    @(negedge clk);
    core_done = 0;
    repeat (2) @(negedge clk);
    check("R6 waits core2", 32'(xlat_deact), 0);
    core_done = 4'b0100;
    @(negedge clk);
    core_done = 0;
    check("R6 masked done", 32'(xlat_deact), 32'h3f);
    @(negedge clk);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    cfg_write(0, 8'h00);
    send_cmd(5);
    count_srst(n);
    check("R6 zero mask deact", 32'(xlat_deact), 0);
    @(negedge clk);
    check("R6 zero mask deact next", 32'(xlat_deact), 32'h3f);
    @(negedge clk);
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
    cfg_write(0, 8'h0f);
  endtask

  task automatic t_busy();
    int n;
    send_cmd(5);
    cmd_valid = 1; cmd_dest = 5;
    count_srst(n);
    check("R9 srst not extended", 32'(n), RSTC);
    repeat (3) begin
      @(negedge clk);
      check("R9 cmd in wait ignored", 32'(core_srst), 0);
    end
    cmd_valid = 0;
    cfg_write(0, 8'h00);
    cfg_write(1, 8'h09);
    repeat (2) @(negedge clk);
    check("R10 locked cfg", 32'(xlat_deact), 0);
    finish_run(5, "R10 locked id");
  endtask

  task automatic t_early();
    int n;
    send_cmd(5);
    core_done = '1;
    count_srst(n);
    core_done = '0;
    repeat (4) begin
      @(negedge clk);
      check("R11 reset-phase done ignored", 32'(xlat_deact), 0);
    end
    finish_run(5, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ident();
    t_mask();
    t_busy();
    t_early();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule